// File: doc/BRIEF.md
# EEPROM Status and Write Guard

This unit sits next to the command decoder of a serial EEPROM and holds the status byte: a status-lock bit, a two-bit block-protect field, the write-enable latch and the write-busy flag. The decoder pulses it with enable and disable commands, status-write and array-write requests. The write timer pulses it when a self-timed cycle starts and when it finishes. The unit answers each request in the same cycle with an accept or reject, and it presents the status byte for readback.

Protection works at two levels. The block-protect field marks the top quarter, the top half or all of the array as read-only for array writes. The status-lock bit, together with an active-low write-protect pin, freezes the status byte against status writes. A status write that is accepted does not alter the protection bits at once. The new value is held aside and moves into the live register only when the timer reports completion. The persistent bits are ordinary flops with a zero reset value.

Top module: `eeprom_guard`

## Requirements
- R1: The status byte reads, from bit 7 down to bit 0, as {lock, 0, 0, 0, bp[1], bp[0], wel, wip}. It is 8'h00 after reset.
- R2: The enable command sets wel and the disable command clears it. When both arrive together, the disable command wins.
- R3: A status write is accepted only while wel=1, wip=0 and the unit is not in hardware-locked mode. A rejected request changes nothing.
- R4: An array write is accepted only while wel=1, wip=0 and the requested page lies outside the protected region.
- R5: wip rises in the cycle after a start pulse and falls in the cycle after a done pulse. Done takes priority over start.
- R6: The lock bit and bp keep their old values while an accepted status write is pending. On done they take bits 7, 3 and 2 of the accepted data byte. Data bits 6, 5, 4, 1 and 0 are ignored.
- R7: Every done pulse clears wel, whether it ends a status write or an array write.
- R8: Hardware-locked mode holds whenever lock=1 and the write-protect pin is low, whichever became true first. Driving the pin high ends the mode.
- R9: Regions by bp: 00 protects nothing, 01 the upper quarter, 10 the upper half, 11 every page. Pages are addr[10:5] of a 2048-byte array, so with bp=01 page 0x2F (0x5E0) is writable and page 0x30 (0x600) is not.
- R10: The protected flag output reflects the page captured by the most recent array-write request, judged against the current bp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wp_pin_n_i | input | 1 | Write-protect pin, low means protect |
| cmd_wren_i | input | 1 | Enable command pulse |
| cmd_wrdi_i | input | 1 | Disable command pulse |
| sts_req_i | input | 1 | Status-write request pulse |
| sts_data_i | input | 8 | Data byte of the status write |
| arr_req_i | input | 1 | Array-write request pulse |
| arr_page_i | input | 6 | Page index of the array write |
| wr_start_i | input | 1 | Timer started a self-timed cycle |
| wr_done_i | input | 1 | Timer finished the cycle |
| status_o | output | 8 | Status byte for readback |
| sts_ok_o | output | 1 | Status write accepted (same cycle) |
| arr_ok_o | output | 1 | Array write accepted (same cycle) |
| arr_prot_o | output | 1 | Captured page is protected |

## Verification
Some rules can be checked on every cycle, and these are written as assertions. No accept is issued while busy or without the enable latch. No status write is accepted while lock and pin together lock the unit. Start, done and disable each reach the status byte one cycle later. The protection bits hold still while a cycle runs. Other behaviour shows only in the bench's scenarios: the deferred value appearing exactly at done, the lock being entered in either order and released by the pin, the page boundary at 0x600, and long random runs compared against a reference model.

// File: rtl/eeprom_guard_pkg.sv
`timescale 1ns/1ps
package eeprom_guard_pkg;

   // Protection configuration, kept as one unit so it can be deferred
   typedef struct packed {
      logic       lock;
      logic [1:0] bp;
   } prot_cfg_t;

   localparam int STS_LOCK_BIT = 7;
   localparam int STS_BP_HI    = 3;
   localparam int STS_BP_LO    = 2;

   function automatic logic [7:0] pack_status(prot_cfg_t c, logic wel, logic wip);
      return {c.lock, 3'b000, c.bp, wel, wip};
   endfunction

   function automatic prot_cfg_t cfg_from_byte(logic [7:0] d);
      prot_cfg_t c;
      c.lock = d[STS_LOCK_BIT];
      c.bp   = d[STS_BP_HI:STS_BP_LO];
      return c;
   endfunction

endpackage

// File: rtl/eeprom_guard_region.sv
`timescale 1ns/1ps
module eeprom_guard_region #(
   parameter int PAGE_W = 6
) (
   input  logic [PAGE_W-1:0] page_i,
   input  logic [1:0]        bp_i,
   output logic              prot_o
);
   localparam int TOP = PAGE_W - 1;

   generate
      if (PAGE_W < 2) begin : g_bad
         $error("eeprom_guard_region: PAGE_W must be at least 2");
      end
   endgenerate

   // Upper quarter: two top bits set; upper half: top bit set
   always_comb begin
      unique case (bp_i)
         2'b00:   prot_o = 1'b0;
         2'b01:   prot_o = page_i[TOP] & page_i[TOP-1];
         2'b10:   prot_o = page_i[TOP];
         default: prot_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/eeprom_guard_regs.sv
`timescale 1ns/1ps
module eeprom_guard_regs
   import eeprom_guard_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      set_wel_i,
   input  logic      clr_wel_i,
   input  logic      take_i,
   input  prot_cfg_t take_val_i,
   input  logic      start_i,
   input  logic      done_i,
   output prot_cfg_t cfg_o,
   output logic      wel_o,
   output logic      wip_o
);
   prot_cfg_t cfg_q, pend_q;
   logic      pend_v_q, wel_q, wip_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q    <= '0;
         pend_q   <= '0;
         pend_v_q <= 1'b0;
         wel_q    <= 1'b0;
         wip_q    <= 1'b0;
      end else begin
         if (done_i)       wip_q <= 1'b0;
         else if (start_i) wip_q <= 1'b1;

         if (done_i || clr_wel_i) wel_q <= 1'b0;
         else if (set_wel_i)      wel_q <= 1'b1;

         if (take_i) begin
            pend_q   <= take_val_i;
            pend_v_q <= 1'b1;
         end else if (done_i) begin
            pend_v_q <= 1'b0;
         end

         // deferred value lands only when the cycle completes
         if (done_i && pend_v_q) cfg_q <= pend_q;
      end
   end

   assign cfg_o = cfg_q;
   assign wel_o = wel_q;
   assign wip_o = wip_q;
endmodule

// File: rtl/eeprom_guard.sv
`timescale 1ns/1ps
module eeprom_guard
   import eeprom_guard_pkg::*;
#(
   parameter int ADDR_W     = 11,
   parameter int PAGE_BYTES = 32,
   localparam int OFS_W     = $clog2(PAGE_BYTES),
   localparam int PAGE_W    = ADDR_W - OFS_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wp_pin_n_i,
   input  logic              cmd_wren_i,
   input  logic              cmd_wrdi_i,
   input  logic              sts_req_i,
   input  logic [7:0]        sts_data_i,
   input  logic              arr_req_i,
   input  logic [PAGE_W-1:0] arr_page_i,
   input  logic              wr_start_i,
   input  logic              wr_done_i,
   output logic [7:0]        status_o,
   output logic              sts_ok_o,
   output logic              arr_ok_o,
   output logic              arr_prot_o
);
   generate
      if ((1 << OFS_W) != PAGE_BYTES) begin : g_pg_chk
         $error("eeprom_guard: PAGE_BYTES must be a power of two");
      end
      if (PAGE_W < 2) begin : g_aw_chk
         $error("eeprom_guard: ADDR_W too small for four regions");
      end
   endgenerate

   prot_cfg_t         cfg;
   logic              wel, wip, hw_lock;
   logic [PAGE_W-1:0] page_q;
   logic [PAGE_W-1:0] pages [2];
   logic [1:0]        prot;
   logic              unused_data;

   assign unused_data = ^{sts_data_i[6:4], sts_data_i[1:0]};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        page_q <= '0;
      else if (arr_req_i) page_q <= arr_page_i;
   end

   // index 0: page offered now, index 1: page captured at command time
   assign pages[0] = arr_page_i;
   assign pages[1] = page_q;

   generate
      for (genvar g = 0; g < 2; g++) begin : g_region
         eeprom_guard_region #(.PAGE_W(PAGE_W)) u_region (
            .page_i (pages[g]),
            .bp_i   (cfg.bp),
            .prot_o (prot[g])
         );
      end
   endgenerate

   assign hw_lock  = cfg.lock & ~wp_pin_n_i;
   assign sts_ok_o = sts_req_i & wel & ~wip & ~hw_lock;
   assign arr_ok_o = arr_req_i & wel & ~wip & ~prot[0];

   eeprom_guard_regs u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_wel_i  (cmd_wren_i),
      .clr_wel_i  (cmd_wrdi_i),
      .take_i     (sts_ok_o),
      .take_val_i (cfg_from_byte(sts_data_i)),
      .start_i    (wr_start_i),
      .done_i     (wr_done_i),
      .cfg_o      (cfg),
      .wel_o      (wel),
      .wip_o      (wip)
   );

   assign status_o   = pack_status(cfg, wel, wip);
   assign arr_prot_o = prot[1];
endmodule

// File: rtl/eeprom_guard_chk.sv
`timescale 1ns/1ps
module eeprom_guard_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       wp_pin_n_i,
   input logic       cmd_wrdi_i,
   input logic       wr_start_i,
   input logic       wr_done_i,
   input logic [7:0] status_o,
   input logic       sts_ok_o,
   input logic       arr_ok_o
);
   logic unused_bits;
   assign unused_bits = ^status_o[6:4];

   // R3
   sts_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sts_ok_o |-> (status_o[1] && !status_o[0]));

   // R4
   arr_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arr_ok_o |-> (status_o[1] && !status_o[0]));

   // R8
   hw_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_o[7] && !wp_pin_n_i) |-> !sts_ok_o);

   // R2
   wel_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_wrdi_i |=> !status_o[1]);

   // R5
   wip_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_start_i && !wr_done_i) |=> status_o[0]);

   // R7
   done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_done_i |=> (!status_o[1] && !status_o[0]));

   // R6
   cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_o[0] && !wr_done_i) |=> $stable({status_o[7], status_o[3:2]}));
endmodule

bind eeprom_guard eeprom_guard_chk u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .wp_pin_n_i (wp_pin_n_i),
   .cmd_wrdi_i (cmd_wrdi_i),
   .wr_start_i (wr_start_i),
   .wr_done_i  (wr_done_i),
   .status_o   (status_o),
   .sts_ok_o   (sts_ok_o),
   .arr_ok_o   (arr_ok_o)
);

// File: tb/eeprom_guard_tb_top.sv
`timescale 1ns/1ps
module eeprom_guard_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wp_r = 1'b1;
   logic       wren = 0, wrdi = 0, sts = 0, arr = 0, st = 0, dn = 0;
   logic [7:0] sdat = '0;
   logic [5:0] pg = '0;
   logic [7:0] status;
   logic       sts_ok, arr_ok, arr_prot;

   int total = 0;
   int bad = 0;
   bit fin = 0;

   // reference model state
   logic [2:0] m_cfg = '0, m_pend = '0;
   logic       m_wel = 0, m_wip = 0, m_pv = 0;
   logic [5:0] m_page = '0;
   logic       last_sok, last_aok;

   always #5 clk = ~clk;

   eeprom_guard dut_i (
      .clk_i(clk), .rst_ni(rst_n), .wp_pin_n_i(wp_r),
      .cmd_wren_i(wren), .cmd_wrdi_i(wrdi),
      .sts_req_i(sts), .sts_data_i(sdat),
      .arr_req_i(arr), .arr_page_i(pg),
      .wr_start_i(st), .wr_done_i(dn),
      .status_o(status), .sts_ok_o(sts_ok), .arr_ok_o(arr_ok), .arr_prot_o(arr_prot)
   );

   function automatic logic prot_f(logic [5:0] p, logic [1:0] bp);
      case (bp)
         2'b00:   return 1'b0;
         2'b01:   return p[5] & p[4];
         2'b10:   return p[5];
         default: return 1'b1;
      endcase
   endfunction

   function automatic logic [7:0] m_byte();
      return {m_cfg[2], 3'b000, m_cfg[1:0], m_wel, m_wip};
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input logic a_wren, input logic a_wrdi, input logic a_sts,
                       input logic [7:0] a_d, input logic a_arr, input logic [5:0] a_pg,
                       input logic a_st, input logic a_dn);
      logic es, ea;
      @(negedge clk);
      wren = a_wren; wrdi = a_wrdi; sts = a_sts; sdat = a_d;
      arr = a_arr; pg = a_pg; st = a_st; dn = a_dn;
      #1;
      es = a_sts & m_wel & ~m_wip & ~(m_cfg[2] & ~wp_r);
      ea = a_arr & m_wel & ~m_wip & ~prot_f(a_pg, m_cfg[1:0]);
      last_sok = sts_ok;
      last_aok = arr_ok;
      chk("R3", {7'b0, sts_ok}, {7'b0, es});
      chk("R4", {7'b0, arr_ok}, {7'b0, ea});
      // model update from pre-edge state
      if (a_dn && m_pv) m_cfg = m_pend;
      if (es) begin m_pend = {a_d[7], a_d[3:2]}; m_pv = 1; end
      else if (a_dn) m_pv = 0;
      if (a_dn) m_wip = 0; else if (a_st) m_wip = 1;
      if (a_dn || a_wrdi) m_wel = 0; else if (a_wren) m_wel = 1;
      if (a_arr) m_page = a_pg;
      @(posedge clk);
      #1;
      wren = 0; wrdi = 0; sts = 0; arr = 0; st = 0; dn = 0;
      chk("R1", status, m_byte());
      chk("R10", {7'b0, arr_prot}, {7'b0, prot_f(m_page, m_cfg[1:0])});
   endtask

   task automatic idle();
      step(0, 0, 0, 8'h00, 0, 6'h00, 0, 0);
   endtask

   initial begin
      #1_500_000;
      if (!fin) begin
         total++; bad++;
         $display("FAIL R5 watchdog act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0B17));
      repeat (3) @(posedge clk);
      #1;
      chk("R1", status, 8'h00);
      @(negedge clk); rst_n = 1;

      // R2: set then clear the latch, disable wins over enable
      step(1, 0, 0, 0, 0, 0, 0, 0); chk("R2", status, 8'h02);
      step(0, 1, 0, 0, 0, 0, 0, 0); chk("R2", status, 8'h00);
      step(1, 1, 0, 0, 0, 0, 0, 0); chk("R2", status, 8'h00);
      // R3: no latch, rejected
      step(0, 0, 1, 8'hFF, 0, 0, 0, 0); chk("R3", {7'b0, last_sok}, 8'h00);
      // R6: deferred update, ignored data bits
      step(1, 0, 0, 0, 0, 0, 0, 0);
      step(0, 0, 1, 8'hFF, 0, 0, 0, 0); chk("R6", status, 8'h02);
      step(0, 0, 0, 0, 0, 0, 1, 0);     chk("R5", status, 8'h03);
      idle();                           chk("R6", status, 8'h03);
      step(0, 0, 0, 0, 0, 0, 0, 1);     chk("R7", status, 8'h8C);
      // R8: lock set first, pin low second
      wp_r = 0;
      step(1, 0, 0, 0, 0, 0, 0, 0);
      step(0, 0, 1, 8'h00, 0, 0, 0, 0); chk("R8", {7'b0, last_sok}, 8'h00);
      chk("R8", status, 8'h8E);
      wp_r = 1;
      step(0, 0, 1, 8'h04, 0, 0, 0, 0); chk("R8", {7'b0, last_sok}, 8'h01);
      step(0, 0, 0, 0, 0, 0, 1, 0);
      step(0, 0, 0, 0, 0, 0, 0, 1);     chk("R8", status, 8'h04);
      // R8: pin already high, lock written, then pin low
      step(1, 0, 0, 0, 0, 0, 0, 0);
      step(0, 0, 1, 8'h84, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 1, 0);
      step(0, 0, 0, 0, 0, 0, 0, 1);     chk("R8", status, 8'h84);
      wp_r = 0;
      step(1, 0, 0, 0, 0, 0, 0, 0);
      step(0, 0, 1, 8'h00, 0, 0, 0, 0); chk("R8", status, 8'h86);
      wp_r = 1;
      // R9 / R10: quarter boundary with bp=01
      step(0, 0, 0, 0, 1, 6'h2F, 0, 0); chk("R9", {7'b0, last_aok}, 8'h01);
      chk("R10", {7'b0, arr_prot}, 8'h00);
      step(0, 0, 0, 0, 1, 6'h30, 0, 0); chk("R9", {7'b0, last_aok}, 8'h00);
      chk("R10", {7'b0, arr_prot}, 8'h01);
      step(0, 0, 0, 0, 1, 6'h2F, 0, 0);
      step(0, 0, 0, 0, 0, 0, 1, 0);
      step(0, 0, 0, 0, 0, 0, 0, 1);     chk("R7", status, 8'h84);

      // constrained random against the model
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = $urandom % 10;
         case (r)
            0, 1: step(1, 0, 0, 0, 0, 0, 0, 0);
            2:    step(0, 1, 0, 0, 0, 0, 0, 0);
            3, 4: step(0, 0, 1, 8'($urandom), 0, 0, 0, 0);
            5, 6: step(0, 0, 0, 0, 1, 6'($urandom), 0, 0);
            7:    step(0, 0, 0, 0, 0, 0, !m_wip, 0);
            8:    step(0, 0, 0, 0, 0, 0, 0, m_wip);
            default: begin
               wp_r = ~wp_r;
               idle();
            end
         endcase
      end

      fin = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule